// File: doc/BRIEF.md
# Compare-match interval timer

A small timer peripheral with a configurable number of channels (two by default). Each channel divides the system clock down by a selectable prescaler. On every prescaled tick it advances a counter. When the counter reaches a programmable compare value, the channel raises a sticky match flag. On the following tick the counter returns to zero, so the channel produces a regular interval of compare + 1 ticks. An optional level interrupt follows the flag.

Software drives the block through a simple synchronous word-addressed register bus. Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the addressed register. A single run register starts and freezes the channels individually. A counter written while its channel is running picks up the new value only after a short synchronisation window measured in prescaled ticks.

Top module: `cmpm_timer`

## Requirements
- R1: Word 0 is the run register. Bit n = 1 lets channel n count and bit n = 0 freezes its counter. The register reads back as written in bits NCH-1:0, and the bits above read 0.
- R2: Channel n occupies three consecutive words: control/status at 1+3n, counter at 2+3n and compare at 3+3n. A write to one channel never changes another channel.
- R3: Control/status layout: bit 7 is the match flag, bit 6 the interrupt enable and bits 1:0 the prescaler select. All other bits read 0.
- R4: Select 0, 1, 2 and 3 divide the clock by 8, 32, 128 and 512. After the run bit is written, the counter first advances on the D-th clock edge (D = divisor) and every D edges after that.
- R5: Writing control/status with bit 7 = 0 clears the flag, and writing bit 7 = 1 leaves it unchanged. A match in the same cycle wins over a clear.
- R6: On a tick, the counter moves to 0 if it equals the compare value and otherwise increments. The flag sets on the edge where the counter takes the compare value, so one period is compare + 1 ticks.
- R7: Matching is on equality only. A counter above the compare value keeps counting to all ones, wraps to 0 and matches only when it comes back up to the compare value.
- R8: The channel interrupt output is high exactly while both the match flag and the interrupt enable are 1.
- R9: A counter write while the channel runs is held back. Reads return the old, still counting value until the second prescaled tick after the write. On that tick the counter takes the written value instead of incrementing.
- R10: A counter write while the channel is stopped takes effect on the write edge and cancels any held value.
- R11: After reset the run, control/status and counter registers read 0, the compare register reads all ones, and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | AW = clog2(1+3*NCH) | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed word |
| irq | output | NCH | Per-channel match interrupt |

## Verification
The bench builds the block with an 8-bit counter and keeps the other parameters at their defaults: two channels, a divide-by-8 base and a two-tick synchronisation window. The narrow counter brings a full wrap past all ones within about two thousand clock cycles, so missed-match recovery and random compare/start pairs that straddle the wrap fit in a short run. Random cases mix the select values, start values below and above the compare value, and run lengths. Each case is compared with counts worked out in bench functions from elapsed cycles and the divisor.

// File: rtl/cmpm_pkg.sv
package cmpm_pkg;
    // Register word width on the bus.
    localparam int unsigned REG_W = 16;
    // Control/status field positions.
    localparam int unsigned FLAG_BIT = 7;
    localparam int unsigned IE_BIT = 6;
    localparam int unsigned SEL_W = 2;
    // Channel register word offsets inside a channel block.
    localparam int unsigned OFS_CSR = 0;
    localparam int unsigned OFS_CNT = 1;
    localparam int unsigned OFS_CMP = 2;
    localparam int unsigned WORDS_PER_CH = 3;

    function automatic int unsigned ch_word(input int unsigned ch, input int unsigned ofs);
        return 1 + WORDS_PER_CH * ch + ofs;
    endfunction
endpackage

// File: rtl/cmpm_prescaler.sv
module cmpm_prescaler #(
    parameter int unsigned BASE_LOG = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic [cmpm_pkg::SEL_W-1:0]  sel,
    output logic                        tick
);
    localparam int unsigned PW = BASE_LOG + 2 * ((1 << cmpm_pkg::SEL_W) - 1);

    logic [PW-1:0] pcnt_d, pcnt_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim    = (PW'(1) << (BASE_LOG + 2 * int'(sel))) - PW'(1);
        tick   = run && (pcnt_q >= lim);
        pcnt_d = (!run || tick) ? '0 : pcnt_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
endmodule

// File: rtl/cmpm_channel.sv
module cmpm_channel #(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned BASE_LOG   = 3,
    parameter int unsigned SYNC_TICKS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       wr_csr,
    input  logic                       wr_cnt,
    input  logic                       wr_cmp,
    input  logic [cmpm_pkg::REG_W-1:0] wdata,
    output logic [cmpm_pkg::REG_W-1:0] csr_o,
    output logic [cmpm_pkg::REG_W-1:0] cnt_o,
    output logic [cmpm_pkg::REG_W-1:0] cmp_o,
    output logic                       irq
);
    import cmpm_pkg::*;

    localparam int unsigned LW = $clog2(SYNC_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] pend_val;
        logic [LW-1:0]    pend_left;
        logic             pend_vld;
        logic             flag;
        logic             ie;
        logic [SEL_W-1:0] sel;
    } ch_state_t;

    ch_state_t d, q;
    logic      tick;
    logic [CNT_W-1:0] cnt_step;
    logic      unused_wdata;

    assign unused_wdata = ^wdata;

    cmpm_prescaler #(.BASE_LOG(BASE_LOG)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (q.sel),
        .tick  (tick)
    );

    always_comb begin
        d        = q;
        cnt_step = (q.cnt == q.cmp) ? '0 : q.cnt + 1'b1;

        if (wr_csr) begin
            d.ie  = wdata[IE_BIT];
            d.sel = wdata[SEL_W-1:0];
            if (!wdata[FLAG_BIT]) d.flag = 1'b0;
        end

        if (wr_cmp) d.cmp = wdata[CNT_W-1:0];

        if (tick) begin
            if (q.pend_vld && (q.pend_left == LW'(1))) begin
                d.cnt      = q.pend_val;
                d.pend_vld = 1'b0;
            end else begin
                d.cnt = cnt_step;
                if (q.pend_vld) d.pend_left = q.pend_left - LW'(1);
            end
            if (d.cnt == q.cmp) d.flag = 1'b1;
        end

        if (wr_cnt) begin
            if (run) begin
                d.pend_vld  = 1'b1;
                d.pend_val  = wdata[CNT_W-1:0];
                d.pend_left = LW'(SYNC_TICKS);
            end else begin
                d.cnt      = wdata[CNT_W-1:0];
                d.pend_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.cmp <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        csr_o                = '0;
        csr_o[FLAG_BIT]      = q.flag;
        csr_o[IE_BIT]        = q.ie;
        csr_o[SEL_W-1:0]     = q.sel;
        cnt_o                = REG_W'(q.cnt);
        cmp_o                = REG_W'(q.cmp);
        irq                  = q.flag && q.ie;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(q.cnt)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !q.pend_vld) |=> ((q.cnt == '0) || (q.cnt == $past(q.cnt) + 1'b1))); // R7
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag) |-> (q.cnt == $past(q.cmp))); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !wr_csr) |=> q.flag); // R5
endmodule

// File: rtl/cmpm_timer.sv
module cmpm_timer #(
    parameter int unsigned NCH        = 2,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned BASE_LOG   = 3,
    parameter int unsigned SYNC_TICKS = 2,
    localparam int unsigned NWORDS    = 1 + cmpm_pkg::WORDS_PER_CH * NCH,
    localparam int unsigned AW        = $clog2(NWORDS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [AW-1:0]              bus_addr,
    input  logic [cmpm_pkg::REG_W-1:0] bus_wdata,
    output logic [cmpm_pkg::REG_W-1:0] bus_rdata,
    output logic [NCH-1:0]             irq
);
    import cmpm_pkg::*;

    logic [NCH-1:0]   run_d, run_q;
    logic [REG_W-1:0] csr_rd [NCH];
    logic [REG_W-1:0] cnt_rd [NCH];
    logic [REG_W-1:0] cmp_rd [NCH];

    always_comb begin
        run_d = run_q;
        if (bus_we && (bus_addr == AW'(0))) run_d = bus_wdata[NCH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic wr_csr, wr_cnt, wr_cmp;
        assign wr_csr = bus_we && (bus_addr == AW'(ch_word(ch, OFS_CSR)));
        assign wr_cnt = bus_we && (bus_addr == AW'(ch_word(ch, OFS_CNT)));
        assign wr_cmp = bus_we && (bus_addr == AW'(ch_word(ch, OFS_CMP)));

        cmpm_channel #(
            .CNT_W      (CNT_W),
            .BASE_LOG   (BASE_LOG),
            .SYNC_TICKS (SYNC_TICKS)
        ) chan_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_q[ch]),
            .wr_csr (wr_csr),
            .wr_cnt (wr_cnt),
            .wr_cmp (wr_cmp),
            .wdata  (bus_wdata),
            .csr_o  (csr_rd[ch]),
            .cnt_o  (cnt_rd[ch]),
            .cmp_o  (cmp_rd[ch]),
            .irq    (irq[ch])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(0)) bus_rdata[NCH-1:0] = run_q;
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == AW'(ch_word(c, OFS_CSR))) bus_rdata = csr_rd[c];
            if (bus_addr == AW'(ch_word(c, OFS_CNT))) bus_rdata = cnt_rd[c];
            if (bus_addr == AW'(ch_word(c, OFS_CMP))) bus_rdata = cmp_rd[c];
        end
    end

    AST_RUN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == AW'(0))) |=> (run_q == $past(bus_wdata[NCH-1:0]))); // R1
endmodule

// File: tb/cmpm_timer_tb_top.sv
module cmpm_timer_tb_top;
    localparam int NCH   = 2;
    localparam int CNT_W = 8;
    localparam int AW    = $clog2(1 + 3 * NCH);
    localparam int MAXV  = (1 << CNT_W) - 1;
    localparam int HALF  = 2000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_we = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [15:0]    bus_wdata = '0;
    logic [15:0]    bus_rdata;
    logic [NCH-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;

    always #HALF clk = ~clk;

    cmpm_timer #(.NCH(NCH), .CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic int a_csr(int ch); return 1 + 3 * ch; endfunction
    function automatic int a_cnt(int ch); return 2 + 3 * ch; endfunction
    function automatic int a_cmp(int ch); return 3 + 3 * ch; endfunction

    function automatic int exp_cnt(int start, int cmp, int ticks);
        int c = start;
        for (int i = 0; i < ticks; i++) c = (c == cmp) ? 0 : ((c + 1) & MAXV);
        return c;
    endfunction

    function automatic int exp_flag(int start, int cmp, int ticks);
        int c = start;
        int f = 0;
        for (int i = 0; i < ticks; i++) begin
            c = (c == cmp) ? 0 : ((c + 1) & MAXV);
            if (c == cmp) f = 1;
        end
        return f;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        bus_addr  = a[AW-1:0];
        bus_wdata = d[15:0];
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        bus_addr = a[AW-1:0];
        #300;
        d = int'(bus_rdata);
    endtask

    task automatic run_case(int ch, int sel, int cmp, int start, int k, int ie, string req);
        int v;
        int t;
        wr(0, 0);
        wr(a_csr(ch), (ie << 6) | sel);
        wr(a_cnt(ch), start);
        wr(a_cmp(ch), cmp);
        wr(0, 1 << ch);
        repeat (k) @(negedge clk);
        t = k >> (3 + 2 * sel);
        rd(a_cnt(ch), v);
        chk(req, v, exp_cnt(start, cmp, t));
        rd(a_csr(ch), v);
        chk(req, (v >> 7) & 1, exp_flag(start, cmp, t));
        chk({req, " R8 irq"}, int'(irq[ch]), exp_flag(start, cmp, t) & ie);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int v;
        int v2;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset values
        rd(0, v);         chk("R11 run", v, 0);
        rd(a_csr(0), v);  chk("R11 csr", v, 0);
        rd(a_cnt(1), v);  chk("R11 cnt", v, 0);
        rd(a_cmp(0), v);  chk("R11 cmp", v, MAXV);
        chk("R11 irq", int'(irq), 0);

        // R3 field layout: writing ones everywhere does not set the flag
        wr(a_csr(1), 16'hFFFF);
        rd(a_csr(1), v);  chk("R3 csr layout", v, 16'h0043);
        wr(a_csr(1), 0);

        // R2 address map and channel isolation
        wr(a_cmp(1), 8'h5A);
        wr(a_cnt(1), 8'h33);
        rd(a_cmp(1), v);  chk("R2 ch1 cmp", v, 8'h5A);
        rd(a_cnt(1), v);  chk("R2 ch1 cnt", v, 8'h33);
        rd(a_cmp(0), v);  chk("R2 ch0 cmp untouched", v, MAXV);
        rd(a_cnt(0), v);  chk("R2 ch0 cnt untouched", v, 0);

        // R1 run register readback
        wr(0, 3);
        rd(0, v);         chk("R1 run readback", v, 3);
        wr(0, 0);

        // R4 divide by 512: first advance on the 512th edge
        run_case(0, 3, MAXV, 0, 511, 0, "R4 div512 before");
        @(negedge clk);
        rd(a_cnt(0), v);  chk("R4 div512 first tick", v, 1);
        // R4 divide by 32
        run_case(0, 1, MAXV, 0, 31, 0, "R4 div32 before");
        @(negedge clk);
        rd(a_cnt(0), v);  chk("R4 div32 first tick", v, 1);

        // R1 freeze when run bit cleared
        wr(0, 0);
        rd(a_cnt(0), v);
        repeat (100) @(negedge clk);
        rd(a_cnt(0), v2); chk("R1 frozen", v2, v);

        // R6 period compare+1: cmp 3, four ticks returns to 0
        run_case(1, 0, 3, 0, 24, 1, "R6 at match");
        repeat (8) @(negedge clk);
        rd(a_cnt(1), v);  chk("R6 wrap to zero", v, 0);

        // R7 compare below count: 50 -> 255 -> 0 -> 20
        run_case(0, 0, 20, 50, 1800, 1, "R7 before wrap match");
        repeat (8) @(negedge clk);
        rd(a_cnt(0), v);  chk("R7 cnt at match", v, 20);
        rd(a_csr(0), v);  chk("R7 flag after wrap", (v >> 7) & 1, 1);

        // R5 and R8 flag write semantics
        wr(0, 0);
        wr(a_csr(0), 16'h00C0);
        rd(a_csr(0), v);  chk("R5 write one keeps flag", v, 16'h00C0);
        chk("R8 irq high", int'(irq[0]), 1);
        wr(a_csr(0), 16'h0080);
        rd(a_csr(0), v);  chk("R8 ie off", v, 16'h0080);
        chk("R8 irq masked", int'(irq[0]), 0);
        wr(a_csr(0), 16'h0040);
        rd(a_csr(0), v);  chk("R5 write zero clears", (v >> 7) & 1, 0);
        chk("R8 irq cleared", int'(irq[0]), 0);

        // R9 counter write while running
        run_case(0, 0, MAXV, 0, 40, 0, "R9 setup");
        wr(a_cnt(0), 100);
        repeat (6) @(negedge clk);
        rd(a_cnt(0), v);  chk("R9 old value held", v, 5);
        @(negedge clk);
        rd(a_cnt(0), v);  chk("R9 first tick counts", v, 6);
        repeat (8) @(negedge clk);
        rd(a_cnt(0), v);  chk("R9 applied on second tick", v, 100);
        repeat (8) @(negedge clk);
        rd(a_cnt(0), v);  chk("R9 counts on", v, 101);

        // R10 counter write while stopped
        wr(0, 0);
        wr(a_cnt(0), 42);
        rd(a_cnt(0), v);  chk("R10 immediate", v, 42);

        // Random cases R6 R7
        for (int i = 0; i < 24; i++) begin
            int ch    = int'($urandom_range(0, 1));
            int sel   = int'($urandom_range(0, 2));
            int cmp   = int'($urandom_range(0, MAXV));
            int start = int'($urandom_range(0, MAXV));
            int k     = int'($urandom_range(0, 2200));
            int ie    = int'($urandom_range(0, 1));
            run_case(ch, sel, cmp, start, k, ie, "R6 R7 random");
        end

        wr(0, 0);
        summary();
        $finish;
    end
endmodule